// File: doc/BRIEF.md
# Windowed Persistent Threshold Interrupt

This block watches a stream of 16-bit light-sensor results and raises an alarm when the readings stay outside a programmed window. The window is set by two 8-bit threshold bytes. Each byte supplies the upper half of a 16-bit limit, and the lower half is zero. A result counts as out of window only when it is strictly above the high limit or strictly below the low limit.

The alarm does not fire on a single stray reading. A 2-bit persistence code sets how many out-of-window results must arrive in a row before the alarm fires. Any in-window result restarts that run.

Once the alarm fires, a sticky flag is set and the pull-down enable of an open-drain interrupt line is asserted. Both stay set until the host clears them. The host can clear them with a dedicated clear strobe or with a strobe that writes zero to the flag. Decoding the host's register accesses and producing the conversion results both happen outside this block.

Top module: `persist_window_irq`

## Requirements
- R1: The high limit is {thr_hi, 8'h00} and the low limit is {thr_lo, 8'h00}. A result is out of window only if it is strictly greater than the high limit or strictly less than the low limit. A result equal to either limit is in window.
- R2: The persistence code sets the number of consecutive out-of-window results needed to fire the alarm: code 0 needs 1, code 1 needs 4, code 2 needs 8 and code 3 needs 16. The internal run count saturates at 16.
- R3: Results are evaluated only in cycles where res_valid is 1. Any result value presented without the strobe changes nothing. An in-window result sets the run back to zero.
- R4: On the clock edge that samples the result completing the run, flag becomes 1 and irq_pull becomes 1. irq_pull = 1 means the interrupt line is driven low.
- R5: Once set, flag and irq_pull stay 1 through later results of any value until the host clears them.
- R6: A clr_strobe or a flag_wr0 strobe clears flag and irq_pull on the next edge and zeroes the run. A full new run is then needed to fire the alarm again.
- R7: When a clear and a valid result fall in the same cycle, the clear acts first and the result is then counted from a run of zero. If that result completes the run, the trigger wins and flag stays 1.
- R8: After reset (rst_n low, asynchronous), flag and irq_pull are 0 and the run is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_data | input | 16 | Conversion result |
| res_valid | input | 1 | Strobe marking a new result |
| thr_hi | input | 8 | Upper byte of the high limit |
| thr_lo | input | 8 | Upper byte of the low limit |
| persist_code | input | 2 | Consecutive-result requirement code |
| clr_strobe | input | 1 | Interrupt clear strobe |
| flag_wr0 | input | 1 | Host write of zero to the flag |
| flag | output | 1 | Sticky alarm flag |
| irq_pull | output | 1 | Pull-down enable for the active-low interrupt line |

## Verification
The host clear and a new result can arrive in the same cycle. That collision decides whether the alarm survives, so the bench targets it directly.

With persistence code 0, the bench presents an out-of-window result together with either kind of clear and expects the flag to stay set. With a longer persistence code, it lands a clear on what would be the final result of a run and expects the flag to stay low, because the run restarts from one. The random phase also injects clears at random over strobed results. A bench model applies the clear-then-count order and judges every cycle's flag and interrupt pull against it.

// File: rtl/persist_window_irq.sv
module persist_window_irq #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_valid,
  input  logic [THR_W-1:0]  thr_hi,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [1:0]        persist_code,
  input  logic              clr_strobe,
  input  logic              flag_wr0,
  output logic              flag,
  output logic              irq_pull
);
  localparam int LOW_W  = DATA_W - THR_W;
  localparam int RUN_MAX = 16;
  localparam int RUN_W  = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_MAX);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_base, run_inc, run_need, run_d;
  logic             outside, clear, fire, flag_q;

  assign outside  = (res_data > {thr_hi, {LOW_W{1'b0}}}) ||
                    (res_data < {thr_lo, {LOW_W{1'b0}}});
  assign clear    = clr_strobe | flag_wr0;
  assign run_base = clear ? '0 : run_q;
  assign run_inc  = (run_base == RUN_TOP) ? RUN_TOP : run_base + 1'b1;

  always_comb begin
    case (persist_code)
      2'd0:    run_need = RUN_W'(1);
      2'd1:    run_need = RUN_W'(4);
      2'd2:    run_need = RUN_W'(8);
      default: run_need = RUN_W'(16);
    endcase
  end

  assign run_d = !res_valid ? run_base : (outside ? run_inc : '0);
  assign fire  = res_valid && outside && (run_inc >= run_need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= fire | (flag_q & ~clear);
    end
  end

  assign flag     = flag_q;
  assign irq_pull = flag_q;

  assert_run_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP);
  assert_inwin_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !outside) |=> (run_q == '0));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !clear) |=> $stable(run_q));
  assert_rise_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(res_valid));
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_strobe && !flag_wr0) |=> flag);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_strobe || flag_wr0) && !res_valid) |=> (!flag && run_q == '0));
endmodule

// File: tb/persist_window_irq_bench.sv
module persist_window_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_valid = 1'b0;
  logic [7:0]  thr_hi = 8'hFF;
  logic [7:0]  thr_lo = 8'h00;
  logic [1:0]  persist_code = 2'd0;
  logic        clr_strobe = 1'b0;
  logic        flag_wr0 = 1'b0;
  logic        flag, irq_pull;

  int checks = 0;
  int fails = 0;
  int m_run = 0;
  bit m_flag = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  persist_window_irq u_persist_window_irq (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .persist_code(persist_code),
    .clr_strobe(clr_strobe), .flag_wr0(flag_wr0),
    .flag(flag), .irq_pull(irq_pull));

  function automatic bit is_out(logic [15:0] d, logic [7:0] hi, logic [7:0] lo);
    return (d > {hi, 8'h00}) || (d < {lo, 8'h00});
  endfunction

  function automatic int need_of(logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic check(string req, bit exp_flag);
    checks++;
    if (flag !== exp_flag || irq_pull !== exp_flag) begin
      fails++;
      $display("FAIL %s: flag=%b irq_pull=%b expected %b", req, flag, irq_pull, exp_flag);
    end
  endtask

  task automatic step(string req, logic [15:0] d, bit v, bit clr, bit wr0, bit do_check);
    int base;
    bit fire;
    res_data = d; res_valid = v; clr_strobe = clr; flag_wr0 = wr0;
    base = (clr || wr0) ? 0 : m_run;
    fire = 1'b0;
    if (v) begin
      if (is_out(d, thr_hi, thr_lo)) begin
        m_run = (base >= 16) ? 16 : base + 1;
        fire = (m_run >= need_of(persist_code));
      end else m_run = 0;
    end else m_run = base;
    m_flag = fire || (m_flag && !(clr || wr0));
    @(posedge clk);
    @(negedge clk);
    res_valid = 1'b0; clr_strobe = 1'b0; flag_wr0 = 1'b0;
    if (do_check) check(req, m_flag);
  endtask

  task automatic host_clear(string req);
    step(req, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    #5;
    @(negedge clk);
    check("R8 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", 1'b0);

    // R1: window boundaries, code 0 fires on first out result
    thr_hi = 8'h80; thr_lo = 8'h20; persist_code = 2'd0;
    step("R1 equal high", 16'h8000, 1, 0, 0, 1);
    step("R1 equal low", 16'h2000, 1, 0, 0, 1);
    step("R1 one above high", 16'h8001, 1, 0, 0, 1);
    host_clear("R6 clear strobe");
    step("R1 one below low", 16'h1FFF, 1, 0, 0, 1);
    step("R6 write zero", 16'h0000, 0, 0, 1, 1);

    // R3: no strobe, no effect
    step("R3 unstrobed out value", 16'hFFFF, 0, 0, 0, 1);

    // R2: each persistence code
    for (int c = 1; c < 4; c++) begin
      persist_code = 2'(c);
      for (int i = 0; i < need_of(2'(c)) - 1; i++)
        step("R2 run below need", 16'hF000, 1, 0, 0, 1);
      step("R2 run reaches need", 16'hF000, 1, 0, 0, 1);
      step("R5 sticky on in-window", 16'h5000, 1, 0, 0, 1);
      host_clear("R6 clear after code");
    end

    // R3: in-window breaks a run
    persist_code = 2'd1;
    step("R3 out", 16'h0100, 1, 0, 0, 1);
    step("R3 out", 16'h0100, 1, 0, 0, 1);
    step("R3 out", 16'h0100, 1, 0, 0, 1);
    step("R3 in-window reset", 16'h3000, 1, 0, 0, 1);
    step("R3 out restarts", 16'h0100, 1, 0, 0, 1);
    step("R3 gap without strobe", 16'h5000, 0, 0, 0, 1);
    step("R3 out", 16'h0100, 1, 0, 0, 1);
    step("R3 out", 16'h0100, 1, 0, 0, 1);
    step("R4 fires on fourth", 16'h0100, 1, 0, 0, 1);

    // R6: clear zeroes the run, full new run needed
    host_clear("R6 clear");
    step("R6 after clear 1", 16'hFF00, 1, 0, 0, 1);
    step("R6 after clear 2", 16'hFF00, 1, 0, 0, 1);
    step("R6 after clear 3", 16'hFF00, 1, 0, 0, 1);
    step("R6 after clear 4 fires", 16'hFF00, 1, 0, 0, 1);

    // R7: collision of clear and trigger
    persist_code = 2'd0;
    step("R7 clear with firing result", 16'hFFFF, 1, 1, 0, 1);
    step("R7 wr0 with firing result", 16'hFFFF, 1, 0, 1, 1);
    step("R7 clear with in-window", 16'h4000, 1, 1, 0, 1);
    persist_code = 2'd1;
    step("R7 out", 16'hFFFF, 1, 0, 0, 1);
    step("R7 out", 16'hFFFF, 1, 0, 0, 1);
    step("R7 out", 16'hFFFF, 1, 0, 0, 1);
    step("R7 clear on fourth restarts", 16'hFFFF, 1, 1, 0, 1);

    // R2: saturation through long run then code change
    host_clear("R2 prep");
    persist_code = 2'd3;
    for (int i = 0; i < 20; i++) step("R2 long run", 16'hFFFF, 1, 0, 0, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      int r;
      if (i % 300 == 0) begin
        thr_hi = 8'($urandom_range(255, 64));
        thr_lo = 8'($urandom_range(63, 0));
        persist_code = 2'($urandom_range(3, 0));
      end
      r = $urandom_range(9, 0);
      if (r < 3) d = {thr_hi, 8'h00} + 16'($urandom_range(1, 0));
      else if (r < 5) d = {thr_lo, 8'h00} - 16'($urandom_range(1, 0));
      else if (r < 8) d = 16'($urandom_range(65535, 0));
      else d = {thr_lo + 8'd1, 8'($urandom)};
      step("R7 random", d, $urandom_range(3, 0) != 0,
           $urandom_range(29, 0) == 0, $urandom_range(29, 0) == 0, 1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule